// File: doc/BRIEF.md
# Bus Wait-State Generator

This block lengthens only those bus cycles that reach a slow peripheral. It does not lower the processor clock. It watches the bus phase signal and the peripheral's active-low select. When both show an access in progress, it pulls the processor's ready line low and counts a programmed number of fast system-clock cycles. It then lets ready go high again. The processor is fully static and honours ready on reads and writes alike. Because the block has no direction input, a read and a write are stretched in the same way. Accesses to memory and to other devices never see ready low, so they run at full speed. Software does nothing per access; the only setting is the wait count.

The phase and select inputs may be asynchronous to the system clock, so each one passes through a configurable synchronizer chain. After ready is released, the block stays quiet for the rest of the same access. It arms again once the qualified condition has gone away for at least one synchronized sample.

Top module: `bus_wait_gen`

## Requirements
- R1: While reset is asserted and after it is released, `rdy` is high, and it stays high until a new qualified access is seen.
- R2: An access is qualified when `phi2` is 1 and `sel_n` is 0. `rdy` goes low at the clock edge that is SYNC_STAGES+1 edges after the inputs change; with the default of two stages, that is the third edge.
- R3: For a nonzero `wait_cycles` value N, `rdy` stays low for exactly N consecutive system-clock cycles per access, and then returns high.
- R4: If `sel_n` is 1, or if `phi2` is 0, `rdy` is never pulled low.
- R5: A `wait_cycles` value of zero turns stretching off, and `rdy` stays high during a qualified access.
- R6: While the qualified condition persists after release, no second stall starts. If the condition drops for one synchronized sample and then returns, a new full stall of N cycles starts.
- R7: `wait_cycles` is captured when a stall starts. A change during the stall does not alter that stall's length.
- R8: The largest count, 2^CNT_W-1 (255 by default), gives exactly that many low cycles.
- R9: A synchronous reset during a stall drives `rdy` high after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Bus phase signal; 1 marks the data phase |
| sel_n | input | 1 | Active-low select of the slow peripheral |
| wait_cycles | input | CNT_W | Number of stall cycles; 0 turns stretching off |
| rdy | output | 1 | Processor ready; 0 holds the processor |

## Verification
Qualified accesses are run with short, medium, long and maximum wait counts. These tell apart an off-by-one in the load and release, and show whether the counter's full width is used. Two access patterns carry only one of the two conditions: the phase without the select, and the select without the phase. These show that both conditions are required. A count of zero separates "off" from "one cycle". Holding the select long after release, and then dropping it briefly, separates a one-shot stall from one that retriggers on the same access. Changing the count during a stall, and resetting during a stall, show that the count is captured once and that reset overrides the stall.

// File: rtl/bus_wait_pkg.sv
package bus_wait_pkg;

    localparam int DEF_CNT_W       = 8;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_HOLD  = 2'd2
    } bw_state_e;

    typedef struct packed {
        logic load;
        logic dec;
    } bw_cnt_cmd_t;

    function automatic logic access_hit(input logic phase, input logic sel_low);
        return phase & ~sel_low;
    endfunction

endpackage

// File: rtl/bw_sync.sv
module bw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] ff;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ff <= {STAGES{RST_VAL}};
                end else begin
                    ff[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        ff[i] <= ff[i-1];
                    end
                end
            end
            assign q = ff[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/bw_counter.sv
module bw_counter
    import bus_wait_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  bw_cnt_cmd_t      cmd,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.load) begin
            cnt <= load_val;
        end else if (cmd.dec) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == CNT_W'(1));

    // R3: each decrement lowers the count by exactly one
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && cmd.dec) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/bw_ctrl.sv
module bw_ctrl
    import bus_wait_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        qual,
    input  logic        cfg_zero,
    input  logic        last,
    output bw_cnt_cmd_t cmd,
    output bw_state_e   state
);

    bw_state_e nxt;

    always_comb begin
        nxt      = state;
        cmd.load = 1'b0;
        cmd.dec  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (qual) begin
                    if (cfg_zero) begin
                        nxt = ST_HOLD;
                    end else begin
                        nxt      = ST_STALL;
                        cmd.load = 1'b1;
                    end
                end
            end
            ST_STALL: begin
                if (last) begin
                    nxt = ST_HOLD;
                end else begin
                    cmd.dec = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!qual) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // R5: a zero count never enters the stall state
    a_r5_zero_skip: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && qual && cfg_zero) |=> (state != ST_STALL));

    // R6: a finished access stays parked while the condition persists
    a_r6_hold_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && qual) |=> (state == ST_HOLD));

    // R3: reaching the final count ends the stall
    a_r3_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STALL && last) |=> (state != ST_STALL));

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
    import bus_wait_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phi2,
    input  logic             sel_n,
    input  logic [CNT_W-1:0] wait_cycles,
    output logic             rdy
);

    logic        phi2_s;
    logic        sel_n_s;
    logic        qual;
    logic        last;
    logic [CNT_W-1:0] cnt;
    bw_cnt_cmd_t cmd;
    bw_state_e   state;

    bw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_phi2 (
        .clk (clk),
        .rst (rst),
        .d   (phi2),
        .q   (phi2_s)
    );

    bw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
        .clk (clk),
        .rst (rst),
        .d   (sel_n),
        .q   (sel_n_s)
    );

    assign qual = access_hit(phi2_s, sel_n_s);

    bw_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .qual     (qual),
        .cfg_zero (wait_cycles == '0),
        .last     (last),
        .cmd      (cmd),
        .state    (state)
    );

    bw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (wait_cycles),
        .cnt      (cnt),
        .last     (last)
    );

    assign rdy = (state != ST_STALL);

    // R2, R7: a new stall captures the programmed count
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && qual && wait_cycles != '0)
        |=> (state == ST_STALL && cnt == $past(wait_cycles)));

    // R4: without a qualified access the idle block keeps ready high
    a_r4_idle_ready: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !qual) |=> rdy);

endmodule

// File: tb/bus_wait_gen_tb.sv
module bus_wait_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phi2 = 1'b0;
    logic       sel_n = 1'b1;
    logic [7:0] wait_cycles = 8'd0;
    logic       rdy;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    bus_wait_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .phi2        (phi2),
        .sel_n       (sel_n),
        .wait_cycles (wait_cycles),
        .rdy         (rdy)
    );

    typedef struct packed {
        logic       ph;
        logic       sn;
        logic [7:0] wc;
        int         exp_low;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{1'b1, 1'b0, 8'd1,   1},
        '{1'b1, 1'b0, 8'd3,   3},
        '{1'b1, 1'b0, 8'd7,   7},
        '{1'b0, 1'b0, 8'd5,   0},
        '{1'b1, 1'b1, 8'd5,   0},
        '{1'b1, 1'b0, 8'd0,   0},
        '{1'b1, 1'b0, 8'd16,  16},
        '{1'b1, 1'b0, 8'd2,   2},
        '{1'b1, 1'b0, 8'd255, 255}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle step, sampling after the falling edge
    task automatic step(inout int lows, inout int first, input int idx);
        @(posedge clk);
        @(negedge clk);
        if (!rdy) begin
            lows++;
            if (first < 0) first = idx;
        end
    endtask

    task automatic run_access(input logic ph, input logic sn, input logic [7:0] wc,
                              input int hold, output int lows, output int first);
        lows  = 0;
        first = -1;
        phi2 = ph; sel_n = sn; wait_cycles = wc;
        for (int i = 1; i <= hold; i++) step(lows, first, i);
        phi2 = 1'b0; sel_n = 1'b1;
        for (int j = 1; j <= 8; j++) step(lows, first, hold + j);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..R9 run actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lows;
        int first;
        // R1: ready high during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rdy == 1'b1, "R1 reset", int'(rdy), 1);
        rst = 1'b0;
        lows = 0; first = -1;
        for (int i = 1; i <= 6; i++) step(lows, first, i);
        check(lows == 0, "R1 after reset", lows, 0);

        // table: R2 latency, R3 length, R4 unselected, R5 zero, R8 max
        foreach (VEC[k]) begin
            run_access(VEC[k].ph, VEC[k].sn, VEC[k].wc, int'(VEC[k].wc) + 8, lows, first);
            check(lows == VEC[k].exp_low, "R3/R4/R5/R8 low cycles", lows, VEC[k].exp_low);
            if (VEC[k].exp_low > 0)
                check(first == 3, "R2 latency", first, 3);
        end

        // R6: a long access stalls once, a one-sample drop re-arms
        lows = 0; first = -1;
        phi2 = 1'b1; sel_n = 1'b0; wait_cycles = 8'd3;
        for (int i = 1; i <= 12; i++) step(lows, first, i);
        check(lows == 3, "R6 single stall", lows, 3);
        phi2 = 1'b0;
        step(lows, first, 13);
        phi2 = 1'b1;
        for (int i = 14; i <= 26; i++) step(lows, first, i);
        phi2 = 1'b0; sel_n = 1'b1;
        for (int i = 27; i <= 32; i++) step(lows, first, i);
        check(lows == 6, "R6 rearm after drop", lows, 6);

        // R7: count change mid-stall is ignored
        lows = 0; first = -1;
        phi2 = 1'b1; sel_n = 1'b0; wait_cycles = 8'd6;
        for (int i = 1; i <= 4; i++) step(lows, first, i);
        wait_cycles = 8'd20;
        for (int i = 5; i <= 30; i++) step(lows, first, i);
        phi2 = 1'b0; sel_n = 1'b1;
        for (int i = 31; i <= 36; i++) step(lows, first, i);
        check(lows == 6, "R7 captured count", lows, 6);

        // R9: reset during a stall
        lows = 0; first = -1;
        phi2 = 1'b1; sel_n = 1'b0; wait_cycles = 8'd50;
        for (int i = 1; i <= 6; i++) step(lows, first, i);
        check(rdy == 1'b0, "R3 stall in progress", int'(rdy), 0);
        rst = 1'b1; phi2 = 1'b0; sel_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(rdy == 1'b1, "R9 reset mid stall", int'(rdy), 1);
        rst = 1'b0;
        lows = 0; first = -1;
        for (int i = 1; i <= 10; i++) step(lows, first, i);
        check(lows == 0, "R1 quiet after reset", lows, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule